// File: doc/BRIEF.md
# Two-Wire Slave with Group-Selected Register Access

This block lets an external master on a two-wire serial bus reach an on-chip register space that is split into groups. The bus lines are oversampled on the system clock. Start and stop conditions are found as SDA edges while SCL is high. The first byte of a transfer carries a 7-bit device address and a direction bit. The slave answers a matching address by pulling SDA low in the acknowledge slot. A mismatching address leaves the slave silent until the next start or stop.

In a write transfer, the second byte selects a group. When the group is 0x00, the data bytes that follow load an offset pointer. For any other group, each data byte is written into that group at the pointer, and the pointer then advances by one. The selected group and the pointer persist across transfers. A master therefore reads a register in three steps. It writes the pointer through group 0x00. It selects the target group with a group byte and no data. It then opens a read transfer, and the slave returns consecutive registers MSB first. The read ends when the master answers a byte with a NACK.

Register storage sits outside the block. The block reaches it through a single port with a write strobe and a read strobe. Read data is registered and returns one cycle after the read strobe.

Top module: `gsl_i2c_slave`

## Requirements
- R1: After reset, SDA is released, both register strobes are low, and the group and pointer outputs read 0x00.
- R2: A first byte whose upper seven bits equal the device address is acknowledged (SDA low in the ninth clock). Any other address gets no acknowledge, and every later byte is ignored until the next start or stop: no acknowledge and no register write.
- R3: In a write transfer, the group byte is acknowledged. When the group is 0x00, each data byte loads the pointer and causes no register-file strobe.
- R4: In a write to a non-zero group, each acknowledged data byte (received MSB first) gives one write strobe with that group, the current pointer and the byte. The pointer then advances by one, wrapping from 0xFF to 0x00.
- R5: A first byte with bit 0 = 1 (read) returns registers of the selected group MSB first, starting at the pointer. Each byte the master acknowledges advances the pointer and issues one read strobe. A NACK ends the burst with SDA released.
- R6: A read while group 0x00 is selected returns the pointer value in every byte, with no read strobe and no pointer change.
- R7: A start condition, including one repeated inside a transfer, restarts address matching. A stop returns the slave to idle with SDA released.
- R8: The selected group and the pointer keep their values across stop and start conditions.
- R9: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| rf_we_o | output | 1 | Register write strobe, one cycle |
| rf_re_o | output | 1 | Register read strobe, one cycle |
| rf_group_o | output | 8 | Selected group |
| rf_offset_o | output | 8 | Register offset inside the group (pointer) |
| rf_wdata_o | output | 8 | Write data |
| rf_rdata_i | input | 8 | Read data, valid the cycle after rf_re_o |

## Verification
Every bus event becomes visible to the control logic three system clocks after the pad changes: two synchroniser stages and one edge register. The acknowledge pull and each read data bit therefore appear on SDA within four cycles of an SCL fall. The bench changes the lines and samples them only ten cycles into each SCL phase, which keeps clear of that window. A write strobe comes one cycle after the eighth SCL fall of a data byte is detected, and the pointer moves one cycle later. Prefetched read data lands two cycles after its strobe. The bench therefore checks memory contents, pointer and group only after a stop, and reads data bits only while SCL is high.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GROUP,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } xfer_state_e;

    typedef enum logic [1:0] {
        AN_GROUP,
        AN_WDATA,
        AN_RDATA
    } ack_next_e;

    typedef struct packed {
        xfer_state_e      state;
        ack_next_e        after;
        logic [CNT_W-1:0] bit_cnt;
        byte_t            shreg;
        byte_t            txbuf;
        byte_t            group;
        byte_t            ptr;
        byte_t            wdata;
        logic             rf_we;
        logic             rf_re;
        logic             fetch_pend;
        logic             master_ack;
    } ctrl_t;

endpackage

// File: rtl/gsl_line_sync.sv
module gsl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } line_t;

    line_t q, d;
    logic  scl_now, sda_now;

    assign scl_now = q.scl_pipe[TOP];
    assign sda_now = q.sda_pipe[TOP];

    always_comb begin
        d             = q;
        d.scl_pipe[0] = scl_i;
        d.sda_pipe[0] = sda_i;
        for (int s = 1; s < STAGES; s++) begin
            d.scl_pipe[s] = q.scl_pipe[s-1];
            d.sda_pipe[s] = q.sda_pipe[s-1];
        end
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= d;
    end

    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;
    assign sda_o      = sda_now;

endmodule

// File: rtl/gsl_xfer_ctrl.sv
module gsl_xfer_ctrl
    import gsl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  scl_rise_i,
    input  logic  scl_fall_i,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  sda_i,
    output logic  sda_pull_o,
    output logic  rf_we_o,
    output logic  rf_re_o,
    output byte_t rf_group_o,
    output byte_t rf_offset_o,
    output byte_t rf_wdata_o,
    input  byte_t rf_rdata_i
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    ctrl_t q, d;
    logic  byte_done;

    assign byte_done = scl_fall_i && (q.bit_cnt == FULL);

    always_comb begin
        d            = q;
        d.rf_we      = 1'b0;
        d.rf_re      = 1'b0;
        d.fetch_pend = q.rf_re;
        if (q.fetch_pend) d.txbuf = rf_rdata_i;
        if (q.rf_we)      d.ptr   = q.ptr + 1'b1;

        if (stop_i) begin
            d.state      = ST_IDLE;
            d.bit_cnt    = '0;
            d.master_ack = 1'b0;
        end else if (start_i) begin
            d.state      = ST_ADDR;
            d.bit_cnt    = '0;
            d.master_ack = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_GROUP, ST_WDATA: begin
                    if (scl_rise_i) begin
                        d.shreg   = {q.shreg[BYTE_W-2:0], sda_i};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        d.bit_cnt = '0;
                        d.state   = ST_ACK;
                        if (q.state == ST_ADDR) begin
                            if (q.shreg[BYTE_W-1:1] != SLAVE_ADDR) begin
                                d.state = ST_IGNORE;
                            end else if (q.shreg[0]) begin
                                d.after = AN_RDATA;
                                if (q.group == '0) d.txbuf = q.ptr;
                                else               d.rf_re = 1'b1;
                            end else begin
                                d.after = AN_GROUP;
                            end
                        end else if (q.state == ST_GROUP) begin
                            d.group = q.shreg;
                            d.after = AN_WDATA;
                        end else begin
                            d.after = AN_WDATA;
                            if (q.group == '0) begin
                                d.ptr = q.shreg;
                            end else begin
                                d.rf_we = 1'b1;
                                d.wdata = q.shreg;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.bit_cnt = '0;
                        case (q.after)
                            AN_GROUP: d.state = ST_GROUP;
                            AN_RDATA: d.state = ST_RDATA;
                            default:  d.state = ST_WDATA;
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (scl_rise_i) begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        d.bit_cnt = '0;
                        d.state   = ST_RACK;
                    end else if (scl_fall_i) begin
                        d.txbuf = {q.txbuf[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        if (!sda_i) begin
                            d.master_ack = 1'b1;
                            if (q.group == '0) begin
                                d.txbuf = q.ptr;
                            end else begin
                                d.ptr   = q.ptr + 1'b1;
                                d.rf_re = 1'b1;
                            end
                        end else begin
                            d.state = ST_IGNORE;
                        end
                    end else if (scl_fall_i && q.master_ack) begin
                        d.master_ack = 1'b0;
                        d.bit_cnt    = '0;
                        d.state      = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign sda_pull_o  = (q.state == ST_ACK) ||
                         ((q.state == ST_RDATA) && !q.txbuf[BYTE_W-1]);
    assign rf_we_o     = q.rf_we;
    assign rf_re_o     = q.rf_re;
    assign rf_group_o  = q.group;
    assign rf_offset_o = q.ptr;
    assign rf_wdata_o  = q.wdata;

    a_r9_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rf_we_o && rf_re_o));

    a_r3_no_strobe_in_group0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rf_we_o || rf_re_o) |-> (rf_group_o != '0));

    a_r4_ptr_steps_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_we_o |=> (rf_offset_o == byte_t'($past(rf_offset_o) + 1'b1)));

    a_r2_released_when_ignoring: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IGNORE) |-> !sda_pull_o);

    a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> ((q.state == ST_IDLE) && !sda_pull_o));

endmodule

// File: rtl/gsl_i2c_slave.sv
module gsl_i2c_slave
    import gsl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       rf_we_o,
    output logic       rf_re_o,
    output logic [7:0] rf_group_o,
    output logic [7:0] rf_offset_o,
    output logic [7:0] rf_wdata_o,
    input  logic [7:0] rf_rdata_i
);

    logic scl_rise, scl_fall, start_det, stop_det, sda_sync;

    gsl_line_sync #(
        .STAGES(SYNC_STAGES)
    ) i_line_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_sync)
    );

    gsl_xfer_ctrl #(
        .SLAVE_ADDR(SLAVE_ADDR)
    ) i_xfer_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_i       (sda_sync),
        .sda_pull_o  (sda_pull_o),
        .rf_we_o     (rf_we_o),
        .rf_re_o     (rf_re_o),
        .rf_group_o  (rf_group_o),
        .rf_offset_o (rf_offset_o),
        .rf_wdata_o  (rf_wdata_o),
        .rf_rdata_i  (rf_rdata_i)
    );

endmodule

// File: tb/test_gsl_i2c_slave.sv
module test_gsl_i2c_slave;

    localparam logic [6:0] DEV = 7'h2C;
    localparam int         Q   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull, rf_we, rf_re;
    logic [7:0] rf_group, rf_offset, rf_wdata, rf_rdata;

    logic [7:0] mem     [1024];
    logic [7:0] exp_mem [1024];
    logic [7:0] wbuf    [8];
    logic [7:0] exp_ptr, exp_group;
    int n_checks = 0, n_fail = 0;
    int we_count = 0, re_count = 0, both_seen = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    gsl_i2c_slave #(.SLAVE_ADDR(DEV)) i_gsl_i2c_slave (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .rf_we_o(rf_we), .rf_re_o(rf_re),
        .rf_group_o(rf_group), .rf_offset_o(rf_offset),
        .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
    );

    function automatic logic [9:0] idx(logic [7:0] g, logic [7:0] o);
        return {g[1:0], o};
    endfunction

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 29 + 7);
    endfunction

    // register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
            rf_rdata <= '0;
        end else begin
            if (rf_we) begin mem[idx(rf_group, rf_offset)] <= rf_wdata; we_count++; end
            if (rf_re) begin rf_rdata <= mem[idx(rf_group, rf_offset)]; re_count++; end
            if (rf_we && rf_re) both_seen++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half();
    endtask

    task automatic bus_stop();
        sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half(); scl_m = 1; half(); scl_m = 0; half();
        end
        sda_m = 1; half(); scl_m = 1; half(); nack = sda_line; scl_m = 0; half();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            half(); scl_m = 1; half(); b = {b[6:0], sda_line}; scl_m = 0;
        end
        half(); sda_m = give_ack ? 1'b0 : 1'b1; half();
        scl_m = 1; half(); scl_m = 0; half(); sda_m = 1;
    endtask

    function automatic int mem_mismatches();
        int n = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    // write transfer: group byte then n bytes from wbuf
    task automatic do_write(input logic [7:0] g, input int n, input bit keep_open);
        logic nk;
        bus_start();
        send_byte({DEV, 1'b0}, nk); check("R2 address ack", nk, 0);
        send_byte(g, nk);           check("R3 group ack", nk, 0);
        exp_group = g;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], nk); check("R4 data ack", nk, 0);
            if (g == 0) exp_ptr = wbuf[i];
            else begin exp_mem[idx(g, exp_ptr)] = wbuf[i]; exp_ptr = exp_ptr + 1; end
        end
        if (!keep_open) bus_stop();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        wbuf[0] = p;
        do_write(8'h00, 1, 0);
    endtask

    // read transfer: n bytes, ack all but last
    task automatic do_read(input int n);
        logic nk;
        logic [7:0] b, e;
        int re0;
        re0 = re_count;
        bus_start();
        send_byte({DEV, 1'b1}, nk); check("R5 read address ack", nk, 0);
        for (int i = 0; i < n; i++) begin
            e = (exp_group == 0) ? exp_ptr : exp_mem[idx(exp_group, exp_ptr)];
            recv_byte(b, i != n - 1);
            check((exp_group == 0) ? "R6 group0 read value" : "R5 read data", b, e);
            if (i != n - 1 && exp_group != 0) exp_ptr = exp_ptr + 1;
        end
        repeat (4) @(negedge clk);
        check("R5 sda released after nack", sda_pull, 0);
        bus_stop();
        repeat (4) @(negedge clk);
        check(exp_group == 0 ? "R6 no read strobe" : "R5 read strobe count",
              re_count - re0, exp_group == 0 ? 0 : n);
        check("R5 pointer after read", rf_offset, exp_ptr);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) exp_mem[i] = init_val(i);
        exp_ptr = 0; exp_group = 0;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check("R1 sda released", sda_pull, 0);
        check("R1 write strobe low", rf_we, 0);
        check("R1 read strobe low", rf_re, 0);
        check("R1 pointer", rf_offset, 0);
        check("R1 group", rf_group, 0);

        begin : mismatch
            logic nk;
            int we0;
            we0 = we_count;
            bus_start();
            send_byte({DEV ^ 7'h01, 1'b0}, nk); check("R2 foreign address nack", nk, 1);
            send_byte(8'h01, nk);               check("R2 ignored group byte", nk, 1);
            send_byte(8'hA5, nk);               check("R2 ignored data byte", nk, 1);
            // repeated start recovers
            bus_start();
            send_byte({DEV, 1'b0}, nk);         check("R7 repeated start readdress", nk, 0);
            send_byte(8'h00, nk);               check("R3 group0 ack", nk, 0);
            send_byte(8'h10, nk);               check("R3 pointer byte ack", nk, 0);
            bus_stop();
            repeat (4) @(negedge clk);
            exp_ptr = 8'h10; exp_group = 0;
            check("R2 no write while ignoring", we_count - we0, 0);
            check("R3 pointer loaded", rf_offset, 8'h10);
            check("R7 idle after stop releases sda", sda_pull, 0);
            check("R2 memory untouched", mem_mismatches(), 0);
        end

        // pointer wrap with a burst into group 2
        set_ptr(8'hFE);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(8'h02, 3, 0);
        check("R4 wrap memory", mem_mismatches(), 0);
        check("R4 pointer wrapped", rf_offset, 8'h01);
        check("R8 group kept after stop", rf_group, 8'h02);

        // read back across the wrap, group/ptr kept from previous transfers (R8)
        set_ptr(8'hFE);
        do_write(8'h02, 0, 0);
        do_read(3);

        // group 0 read returns the pointer
        set_ptr(8'h42);
        do_read(3);
        check("R6 pointer unchanged", rf_offset, 8'h42);

        // read via repeated start after group select
        set_ptr(8'h05);
        do_write(8'h01, 0, 1);
        do_read(2);

        // randomized bursts
        for (int it = 0; it < 8; it++) begin
            logic [7:0] g, p;
            int n;
            g = 8'(1 + $urandom_range(2));
            p = 8'($urandom);
            n = 1 + $urandom_range(4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            set_ptr(p);
            do_write(g, n, 0);
            check("R4 random burst memory", mem_mismatches(), 0);
            check("R4 random pointer", rf_offset, 8'(p + n));
            set_ptr(p);
            do_write(g, 0, it[0]);
            do_read(n);
        end

        check("R9 strobes never together", both_seen, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule